// File: doc/BRIEF.md
# ChaCha Double-Round Permutation Core

This block runs the ChaCha add-rotate-xor permutation over a sixteen-word state of 32-bit words. A wrapper puts a 512-bit state (constants, key, nonce, already arranged) on the input bus and pulses a start strobe. The core then applies ten double rounds, which is twenty rounds in all. Each double round runs four quarter-rounds down the columns of the 4x4 word matrix and then four along its diagonals. When the last quarter-round is done, the core raises a one-cycle completion pulse and presents the raw permuted state.

There is one quarter-round datapath, and it is time-shared. It handles one quarter-round per clock, so a full permutation needs eighty working cycles after the load cycle. The feed-forward addition, counter handling and the choice of subkey words are left to the surrounding logic. This makes the core suitable for both the HChaCha subkey derivation and a keystream generator.

Top module: `chacha_perm_core`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o` and `done_o` are both 0.
- R2: A `start_i` that is high at a rising edge while `busy_o` is 0 loads `state_i`, and `busy_o` reads 1 from that edge on.
- R3: `done_o` rises on the 80th rising edge after the edge that accepted the start. On that same edge `busy_o` returns to 0.
- R4: The result is the ten-fold repetition of a double round. Each double round applies quarter-rounds first to the columns (0,4,8,12), (1,5,9,13), (2,6,10,14), (3,7,11,15), then to the diagonals (0,5,10,15), (1,6,11,12), (2,7,8,13), (3,4,9,14).
- R5: A quarter-round on (a,b,c,d) performs these steps in order: a+=b then d=rotl(d^a,16); c+=d then b=rotl(b^c,12); a+=b then d=rotl(d^a,8); c+=d then b=rotl(b^c,7).
- R6: On both `state_i` and `state_o`, word i occupies bits [32i+31:32i].
- R7: A start pulse while `busy_o` is 1 has no effect. The running permutation finishes at its original time with its original result.
- R8: A start that is high in the cycle where `done_o` is 1 is accepted and begins a new permutation.
- R9: `done_o` is high for exactly one cycle per permutation.
- R10: All additions wrap modulo 2^32.
- R11: While the core is idle and no start is accepted, `state_o` holds the last result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control state |
| start_i | input | 1 | Load strobe, taken only when idle |
| state_i | input | 512 | Input state, word i at bits [32i+31:32i] |
| busy_o | output | 1 | Permutation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| state_o | output | 512 | Permuted state, valid from the done pulse on |

## Verification
The one result whose timing matters is the completion pulse and its state. Both are due on the 80th rising edge after the edge that takes the start, and `busy_o` is due one edge after the start. The bench drives and samples on falling edges and counts rising edges explicitly from the accepting edge. It checks that `done_o` stays low for the first 79 edges, then reads `done_o`, `busy_o` and `state_o` right after the 80th edge and once more one edge later. It compares the state with a behavioural model written from the quarter-round definition.

// File: rtl/chacha_pkg.sv
package chacha_pkg;

    localparam int unsigned CW_W      = 32;
    localparam int unsigned N_WORDS   = 16;
    localparam int unsigned IDX_W     = $clog2(N_WORDS);
    localparam int unsigned QR_PER_DR = 8;
    localparam int unsigned STATE_W   = CW_W * N_WORDS;

    typedef logic [CW_W-1:0]  word_t;
    typedef logic [IDX_W-1:0] widx_t;

    typedef struct packed {
        widx_t a;
        widx_t b;
        widx_t c;
        widx_t d;
    } qr_sel_t;

    typedef struct packed {
        word_t a;
        word_t b;
        word_t c;
        word_t d;
    } qr_words_t;

    function automatic word_t rotl(input word_t x, input int unsigned n);
        return (x << n) | (x >> (CW_W - n));
    endfunction

endpackage

// File: rtl/chacha_qr.sv
module chacha_qr
    import chacha_pkg::*;
#(
    parameter int unsigned ROT_0 = 16,
    parameter int unsigned ROT_1 = 12,
    parameter int unsigned ROT_2 = 8,
    parameter int unsigned ROT_3 = 7
) (
    input  qr_words_t in_i,
    output qr_words_t out_o
);

    word_t a1, d1, c1, b1, a2, d2, c2, b2;

    always_comb begin
        a1 = in_i.a + in_i.b;
        d1 = rotl(in_i.d ^ a1, ROT_0);
        c1 = in_i.c + d1;
        b1 = rotl(in_i.b ^ c1, ROT_1);
        a2 = a1 + b1;
        d2 = rotl(d1 ^ a2, ROT_2);
        c2 = c1 + d2;
        b2 = rotl(b1 ^ c2, ROT_3);
        out_o = '{a: a2, b: b2, c: c2, d: d2};
    end

endmodule

// File: rtl/chacha_sched.sv
module chacha_sched
    import chacha_pkg::*;
(
    input  logic [2:0] slot_i,
    output qr_sel_t    sel_o
);

    logic [1:0] lane;
    logic [1:0] skew;

    always_comb begin
        lane  = slot_i[1:0];
        skew  = {1'b0, slot_i[2]};
        sel_o.a = {2'b00, lane};
        sel_o.b = {2'b01, 2'(lane + skew)};
        sel_o.c = {2'b10, 2'(lane + 2'(skew << 1))};
        sel_o.d = {2'b11, 2'(lane + 2'(skew * 2'd3))};
    end

endmodule

// File: rtl/chacha_perm_core.sv
module chacha_perm_core
    import chacha_pkg::*;
#(
    parameter int unsigned DOUBLE_ROUNDS = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [STATE_W-1:0] state_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [STATE_W-1:0] state_o
);

    localparam int unsigned TOTAL_QR = QR_PER_DR * DOUBLE_ROUNDS;
    localparam int unsigned STEP_W   = $clog2(TOTAL_QR);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL_QR - 1);

    typedef struct packed {
        logic                      busy;
        logic                      done;
        logic [STEP_W-1:0]         step;
        word_t [N_WORDS-1:0]       words;
    } core_t;

    core_t core_d, core_q;

    word_t [N_WORDS-1:0] in_words;
    qr_sel_t             sel;
    qr_words_t           qr_in, qr_out;

    for (genvar gi = 0; gi < N_WORDS; gi++) begin : g_pack
        assign in_words[gi]              = state_i[gi*CW_W +: CW_W];
        assign state_o[gi*CW_W +: CW_W]  = core_q.words[gi];
    end

    chacha_sched u_sched (
        .slot_i (core_q.step[2:0]),
        .sel_o  (sel)
    );

    assign qr_in = '{a: core_q.words[sel.a], b: core_q.words[sel.b],
                     c: core_q.words[sel.c], d: core_q.words[sel.d]};

    chacha_qr u_qr (
        .in_i  (qr_in),
        .out_o (qr_out)
    );

    always_comb begin
        core_d      = core_q;
        core_d.done = 1'b0;
        if (!core_q.busy) begin
            if (start_i) begin
                core_d.busy  = 1'b1;
                core_d.step  = '0;
                core_d.words = in_words;
            end
        end else begin
            core_d.words[sel.a] = qr_out.a;
            core_d.words[sel.b] = qr_out.b;
            core_d.words[sel.c] = qr_out.c;
            core_d.words[sel.d] = qr_out.d;
            if (core_q.step == LAST_STEP) begin
                core_d.busy = 1'b0;
                core_d.done = 1'b1;
                core_d.step = '0;
            end else begin
                core_d.step = core_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.busy <= 1'b0;
            core_q.done <= 1'b0;
            core_q.step <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign busy_o = core_q.busy;
    assign done_o = core_q.done;

endmodule

// File: rtl/chacha_perm_core_chk.sv
module chacha_perm_core_chk #(
    parameter int unsigned TOTAL_QR = 80,
    parameter int unsigned STATE_W  = 512
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic               busy_o,
    input logic               done_o,
    input logic [STATE_W-1:0] state_o
);

    logic [15:0] busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                busy_cnt_q <= '0;
        else if (start_i && !busy_o) busy_cnt_q <= '0;
        else if (busy_o)           busy_cnt_q <= busy_cnt_q + 16'd1;
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |-> (!busy_o && !done_o));

    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_cnt_q == 16'(TOTAL_QR)));

    // R3
    busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(state_o));

endmodule

bind chacha_perm_core chacha_perm_core_chk #(
    .TOTAL_QR (TOTAL_QR),
    .STATE_W  (chacha_pkg::STATE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .state_o (state_o)
);

// File: tb/chacha_perm_core_tb.sv
module chacha_perm_core_tb;

    localparam int unsigned SW   = 512;
    localparam int unsigned LAT  = 80;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [SW-1:0] state_i = '0;
    logic          busy_o, done_o;
    logic [SW-1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    chacha_perm_core u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .state_i (state_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .state_o (state_o)
    );

    function automatic logic [31:0] rl(input logic [31:0] x, input int n);
        return (x << n) | (x >> (32 - n));
    endfunction

    function automatic logic [SW-1:0] model(input logic [SW-1:0] s);
        logic [31:0] w [16];
        int grp [8][4] = '{'{0,4,8,12}, '{1,5,9,13}, '{2,6,10,14}, '{3,7,11,15},
                           '{0,5,10,15}, '{1,6,11,12}, '{2,7,8,13}, '{3,4,9,14}};
        logic [SW-1:0] r;
        for (int i = 0; i < 16; i++) w[i] = s[32*i +: 32];
        for (int dr = 0; dr < 10; dr++) begin
            for (int q = 0; q < 8; q++) begin
                int a, b, c, d;
                a = grp[q][0]; b = grp[q][1]; c = grp[q][2]; d = grp[q][3];
                w[a] = w[a] + w[b]; w[d] = rl(w[d] ^ w[a], 16);
                w[c] = w[c] + w[d]; w[b] = rl(w[b] ^ w[c], 12);
                w[a] = w[a] + w[b]; w[d] = rl(w[d] ^ w[a], 8);
                w[c] = w[c] + w[d]; w[b] = rl(w[b] ^ w[c], 7);
            end
        end
        for (int i = 0; i < 16; i++) r[32*i +: 32] = w[i];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [SW-1:0] act,
                       input logic [SW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // drive start on a falling edge, let one rising edge take it
    task automatic kick(input logic [SW-1:0] s);
        start_i = 1'b1;
        state_i = s;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        state_i = ~s;
        chk(busy_o === 1'b1, "R2 busy after accept", SW'(busy_o), SW'(1));
    endtask

    // count edges from the accepting edge; optionally poke start mid-run
    task automatic wait_done(input logic [SW-1:0] exp, input string req, input bit poke);
        bit early = 0;
        for (int k = 1; k < LAT; k++) begin
            if (poke && k == 30) begin
                start_i = 1'b1;
                state_i = {16{32'hdeadbeef}};
            end
            @(posedge clk);
            @(negedge clk);
            start_i = 1'b0;
            if (done_o !== 1'b0 || busy_o !== 1'b1) early = 1;
        end
        chk(!early, "R3 no early done", SW'(early), SW'(0));
        @(posedge clk);
        @(negedge clk);
        chk(done_o === 1'b1, "R3 done on 80th edge", SW'(done_o), SW'(1));
        chk(busy_o === 1'b0, "R3 busy clears with done", SW'(busy_o), SW'(0));
        chk(state_o === exp, req, state_o, exp);
    endtask

    task automatic after_done(input logic [SW-1:0] exp);
        @(posedge clk);
        @(negedge clk);
        chk(done_o === 1'b0, "R9 done one cycle", SW'(done_o), SW'(0));
        chk(state_o === exp, "R11 output held", state_o, exp);
    endtask

    task automatic t_reset();
        chk(busy_o === 1'b0, "R1 busy in reset", SW'(busy_o), SW'(0));
        chk(done_o === 1'b0, "R1 done in reset", SW'(done_o), SW'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o === 1'b0 && done_o === 1'b0, "R1 idle after reset",
            SW'({busy_o, done_o}), SW'(0));
    endtask

    task automatic t_run(input logic [SW-1:0] s, input string req);
        logic [SW-1:0] e = model(s);
        kick(s);
        wait_done(e, req, 1'b0);
        after_done(e);
    endtask

    task automatic t_busy_start();
        logic [SW-1:0] s = {16{32'h01234567}} ^ {8{64'h0f0f0f0f_00000000}};
        logic [SW-1:0] e = model(s);
        kick(s);
        wait_done(e, "R7 start while busy ignored", 1'b1);
        after_done(e);
    endtask

    task automatic t_back_to_back();
        logic [SW-1:0] s0 = {16{32'h9b8d6f43}};
        logic [SW-1:0] s1 = {16{32'h11111111}} + 512'd12345;
        kick(s0);
        wait_done(model(s0), "R4 first of pair", 1'b0);
        kick(s1);
        wait_done(model(s1), "R8 start in done cycle accepted", 1'b0);
        after_done(model(s1));
    endtask

    task automatic t_hold();
        logic [SW-1:0] snap = state_o;
        state_i = '1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(state_o === snap, "R11 idle hold with inputs moving", state_o, snap);
        chk(busy_o === 1'b0, "R11 stays idle", SW'(busy_o), SW'(0));
    endtask

    initial begin
        logic [SW-1:0] ramp, rnd;
        t_reset();
        t_run('0, "R4 all-zero state");
        for (int i = 0; i < 16; i++) ramp[32*i +: 32] = 32'(i) * 32'h01010101 + 32'h100;
        t_run(ramp, "R6 word position ramp");
        t_run('1, "R10 all-ones wrap");
        t_run({16{32'h80000001}}, "R5 quarter-round order");
        for (int n = 0; n < 4; n++) begin
            for (int i = 0; i < 16; i++) rnd[32*i +: 32] = $urandom;
            t_run(rnd, "R4 random state");
        end
        t_busy_start();
        t_back_to_back();
        t_hold();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        summary();
    end

endmodule